// File: doc/BRIEF.md
# Median and Maximum Threshold Tracker

This block derives the two list-pruning thresholds that a list decoder needs at every step from its L current path metrics. The lower threshold is the metric at zero-based rank L/2 of the ascending order (the upper median). Paths better than it are always kept. The upper threshold is the largest metric. Paths worse than it are always dropped.

The L metrics arrive as one flat vector together with a valid strobe. The block never sorts all L values. It splits them into two halves and sorts each half with a small network. It then narrows the position of the median in log2(L)-1 binary-search steps across the two sorted halves, and settles the result with one final step. The maximum takes one comparison of the two half maxima.

The block is fully pipelined. It takes a new metric set every cycle and returns both thresholds a fixed number of cycles later.

Top module: `medMaxTracker`

## Requirements
- R1: When `outValid` is high, `atOut` equals the value at zero-based index L/2 of the ascending sort of the L metrics of the matching input set. For L=8 this is the fifth smallest value.
- R2: When `outValid` is high, `rtOut` equals the largest of the L metrics of the matching input set.
- R3: Metrics 0..L/2-1 form one half and metrics L/2..L-1 form the other. The results are correct however the small and large values are spread between the halves, including when all the smallest lie in one half.
- R4: `outValid` rises exactly 1+log2(L) clock cycles after the cycle in which `inValid` was sampled high. For the default L=8 this is 4 cycles.
- R5: A new input set can be given in every cycle. Results come out one per cycle, in input order.
- R6: Equal metrics are ordered by input index. Sets that contain repeated values, including all-equal sets, still give the correct threshold values.
- R7: While `rst_n` is low, and in the cycles after it is released with no input given, `outValid` is low.
- R8: Metrics are unsigned over the full W-bit range. Sets containing 0 and 2^W-1 give correct thresholds.
- R9: A cycle with `inValid` low produces no output slot. Whatever is on `metricsIn` in that cycle never shows up as a valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | `metricsIn` holds a set to process |
| metricsIn | input | L*W | Metric i occupies bits [i*W +: W], unsigned |
| outValid | output | 1 | Thresholds are valid |
| atOut | output | W | Acceptance threshold (rank L/2 metric) |
| rtOut | output | W | Rejection threshold (largest metric) |

## Verification
A fault in a half-sorter or in one elimination step shows up as a wrong `atOut` value exactly 1+log2(L) cycles after the affected set entered. It can only show up for sets whose median straddles the faulty comparison, so the sets used include skewed, interleaved, descending and tied patterns. A fault in the valid pipeline shows up at once as `outValid` high or low in the wrong cycle. Every cycle of `outValid` is compared against a latency model. A fault in the half-maximum choice corrupts `rtOut` on the first set whose maximum lies in the other half.

// File: rtl/thrPkg.sv
package thrPkg;
  localparam int MAX_SRCH = 8;

  typedef struct packed {
    logic                sortLd;
    logic [MAX_SRCH-1:0] srchLd;
    logic                finLd;
    logic                outVld;
  } thrStrobe_t;
endpackage

// File: rtl/halfSorter.sv
module halfSorter #(
  parameter int H  = 4,
  parameter int KW = 11
) (
  input  logic [H-1:0][KW-1:0] keyIn,
  output logic [H-1:0][KW-1:0] keyOut
);
  logic [H-1:0][KW-1:0] lvl [0:H];

  assign lvl[0] = keyIn;

  for (genvar s = 0; s < H; s++) begin : g_round
    localparam int PAR = s % 2;
    for (genvar i = 0; i < H; i++) begin : g_lane
      if (i >= PAR && ((i - PAR) % 2) == 0 && (i + 1) < H) begin : g_lo
        assign lvl[s+1][i] = (lvl[s][i] < lvl[s][i+1]) ? lvl[s][i] : lvl[s][i+1];
      end else if (i >= PAR + 1 && ((i - PAR) % 2) == 1) begin : g_hi
        assign lvl[s+1][i] = (lvl[s][i-1] < lvl[s][i]) ? lvl[s][i] : lvl[s][i-1];
      end else begin : g_pass
        assign lvl[s+1][i] = lvl[s][i];
      end
    end
  end

  assign keyOut = lvl[H];
endmodule

// File: rtl/thrCtrl.sv
module thrCtrl
  import thrPkg::*;
#(
  parameter int SS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output thrStrobe_t stb,
  output logic       outValid
);
  localparam int STG = SS + 2;

  logic [STG-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[STG-2:0], inValid};
  end

  always_comb begin
    stb            = '0;
    stb.sortLd     = inValid;
    stb.srchLd[SS-1:0] = vld[SS-1:0];
    stb.finLd      = vld[SS];
    stb.outVld     = vld[STG-1];
  end

  assign outValid = vld[STG-1];

  // R4: output valid follows input valid by the fixed pipeline depth
  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == $past(inValid, STG));
endmodule

// File: rtl/thrDatapath.sv
module thrDatapath
  import thrPkg::*;
#(
  parameter int L = 8,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  thrStrobe_t     stb,
  input  logic [L*W-1:0] metricsIn,
  output logic [W-1:0]   atOut,
  output logic [W-1:0]   rtOut
);
  localparam int H  = L / 2;
  localparam int IW = $clog2(L);
  localparam int KW = W + IW;
  localparam int SS = $clog2(H);
  localparam int PW = SS + 1;

  typedef logic [H-1:0][KW-1:0] half_t;

  function automatic logic [KW-1:0] maxK(input logic [KW-1:0] x, input logic [KW-1:0] y);
    return (x > y) ? x : y;
  endfunction

  function automatic logic [KW-1:0] minK(input logic [KW-1:0] x, input logic [KW-1:0] y);
    return (x < y) ? x : y;
  endfunction

  half_t keyA, keyB, sortA, sortB;

  for (genvar i = 0; i < H; i++) begin : g_keys
    assign keyA[i] = {metricsIn[i*W +: W], IW'(i)};
    assign keyB[i] = {metricsIn[(H+i)*W +: W], IW'(H + i)};
  end

  halfSorter #(.H(H), .KW(KW)) sortA_i (.keyIn(keyA), .keyOut(sortA));
  halfSorter #(.H(H), .KW(KW)) sortB_i (.keyIn(keyB), .keyOut(sortB));

  half_t          aReg   [0:SS];
  half_t          bReg   [0:SS];
  logic [KW-1:0]  rtReg  [0:SS];
  logic [PW-1:0]  posReg [0:SS];

  logic halfMaxSel;
  assign halfMaxSel = sortA[H-1] > sortB[H-1];

  always_ff @(posedge clk) begin
    if (stb.sortLd) begin
      aReg[0]   <= sortA;
      bReg[0]   <= sortB;
      rtReg[0]  <= halfMaxSel ? sortA[H-1] : sortB[H-1];
      posReg[0] <= '0;
    end
  end

  // Binary search for the number of leading split points where the
  // A-side key stays below the mirrored B-side key.
  for (genvar s = 0; s < SS; s++) begin : g_srch
    localparam int STEP = H >> (s + 1);
    logic [PW-1:0] cand;
    logic          goLow;

    assign cand  = posReg[s] + PW'(STEP);
    assign goLow = aReg[s][SS'(cand - PW'(1))] > bReg[s][SS'(PW'(H) - cand)];

    always_ff @(posedge clk) begin
      if (stb.srchLd[s]) begin
        aReg[s+1]   <= aReg[s];
        bReg[s+1]   <= bReg[s];
        rtReg[s+1]  <= rtReg[s];
        posReg[s+1] <= goLow ? posReg[s] : cand;
      end
    end
  end

  logic [PW-1:0] posF, hiI;
  logic [KW-1:0] f0, f1, medKey;
  logic [KW-1:0] atKeyQ, rtKeyQ;

  assign posF = posReg[SS];
  assign hiI  = posF + PW'(1);
  assign f1   = maxK(aReg[SS][SS'(posF)], bReg[SS][SS'(PW'(H) - hiI)]);
  assign f0   = maxK(aReg[SS][SS'(posF - PW'(1))], bReg[SS][SS'(PW'(H) - posF)]);
  assign medKey = (posF == '0) ? f1 : minK(f0, f1);

  always_ff @(posedge clk) begin
    if (stb.finLd) begin
      atKeyQ <= medKey;
      rtKeyQ <= rtReg[SS];
    end
  end

  assign atOut = atKeyQ[KW-1:IW];
  assign rtOut = rtKeyQ[KW-1:IW];

  logic unusedBits;
  assign unusedBits = ^{atKeyQ[IW-1:0], rtKeyQ[IW-1:0], stb.srchLd[MAX_SRCH-1:SS]};

  // R3: both registered halves are strictly ascending (keys carry the index)
  for (genvar i = 0; i + 1 < H; i++) begin : g_chk
    p_half_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stb.srchLd[0] |-> (aReg[0][i] < aReg[0][i+1]) && (bReg[0][i] < bReg[0][i+1]));
  end

  // R2: the kept maximum dominates both half tops
  p_max_dominates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.srchLd[0] |-> (rtReg[0] >= aReg[0][H-1]) && (rtReg[0] >= bReg[0][H-1]));

  // R1: the median key lies strictly below the maximum key
  p_median_below_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stb.outVld |-> atKeyQ < rtKeyQ);
endmodule

// File: rtl/medMaxTracker.sv
module medMaxTracker
  import thrPkg::*;
#(
  parameter int L = 8,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inValid,
  input  logic [L*W-1:0] metricsIn,
  output logic           outValid,
  output logic [W-1:0]   atOut,
  output logic [W-1:0]   rtOut
);
  localparam int SS = $clog2(L / 2);

  thrStrobe_t stb;

  thrCtrl #(.SS(SS)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .stb     (stb),
    .outValid(outValid)
  );

  thrDatapath #(.L(L), .W(W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .metricsIn(metricsIn),
    .atOut    (atOut),
    .rtOut    (rtOut)
  );
endmodule

// File: tb/medMaxTracker_tb_top.sv
`timescale 1ns/1ps
module medMaxTracker_tb_top;
  localparam int L   = 8;
  localparam int W   = 8;
  localparam int LAT = 1 + $clog2(L);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           inValid = 1'b0;
  logic [L*W-1:0] metricsIn = '0;
  logic           outValid;
  logic [W-1:0]   atOut, rtOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic         expV  [0:LAT];
  logic [W-1:0] expAt [0:LAT];
  logic [W-1:0] expRt [0:LAT];
  string        expTag[0:LAT];

  always #2.5 clk = ~clk;

  medMaxTracker #(.L(L), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .metricsIn(metricsIn),
    .outValid(outValid), .atOut(atOut), .rtOut(rtOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic refThr(input logic [L*W-1:0] v, output logic [W-1:0] at, output logic [W-1:0] rt);
    int s [L];
    for (int i = 0; i < L; i++) s[i] = int'(v[i*W +: W]);
    for (int i = 1; i < L; i++) begin
      int k = s[i];
      int j = i - 1;
      while (j >= 0 && s[j] > k) begin s[j+1] = s[j]; j--; end
      s[j+1] = k;
    end
    at = W'(s[L/2]);
    rt = W'(s[L-1]);
  endtask

  // One cycle: at a falling edge, update the latency model, check, then drive.
  task automatic step(input logic [L*W-1:0] v, input logic vld, input string tag);
    logic [W-1:0] a, r;
    @(negedge clk);
    for (int i = LAT; i > 0; i--) begin
      expV[i] = expV[i-1]; expAt[i] = expAt[i-1]; expRt[i] = expRt[i-1]; expTag[i] = expTag[i-1];
    end
    refThr(v, a, r);
    expV[0] = vld; expAt[0] = a; expRt[0] = r; expTag[0] = tag;
    check({expTag[LAT], " R4 outValid"}, int'(outValid), int'(expV[LAT]));
    if (expV[LAT] && outValid) begin
      check({expTag[LAT], " R1 atOut"}, int'(atOut), int'(expAt[LAT]));
      check({expTag[LAT], " R2 rtOut"}, int'(rtOut), int'(expRt[LAT]));
    end
    metricsIn = v;
    inValid   = vld;
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + 1; i++) step('0, 1'b0, "idle");
  endtask

  function automatic logic [L*W-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int t [8] = '{a0, a1, a2, a3, a4, a5, a6, a7};
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = W'(t[i]);
    return v;
  endfunction

  task automatic testReset();
    for (int i = 0; i <= LAT; i++) begin expV[i] = 0; expAt[i] = 0; expRt[i] = 0; expTag[i] = "rst"; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 outValid in reset", int'(outValid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step('0, 1'b0, "R7 idle after reset");
  endtask

  task automatic testSingle();
    step(pack8(30, 10, 70, 50, 20, 80, 40, 60), 1'b1, "R4 single set");
    drain();
  endtask

  task automatic testSkew();
    step(pack8(1, 2, 3, 4, 100, 101, 102, 103), 1'b1, "R3 small in first half");
    step(pack8(100, 101, 102, 103, 1, 2, 3, 4), 1'b1, "R3 small in second half");
    step(pack8(1, 100, 3, 102, 2, 101, 4, 103), 1'b1, "R3 interleaved");
    step(pack8(80, 70, 60, 50, 40, 30, 20, 10), 1'b1, "R3 descending");
    step(pack8(5, 90, 6, 7, 8, 9, 10, 11), 1'b1, "R3 one high in first half");
    drain();
  endtask

  task automatic testTies();
    step(pack8(9, 9, 9, 9, 9, 9, 9, 9), 1'b1, "R6 all equal");
    step(pack8(3, 7, 7, 3, 7, 3, 7, 3), 1'b1, "R6 two values");
    step(pack8(5, 5, 5, 5, 6, 6, 6, 6), 1'b1, "R6 split equal halves");
    step(pack8(200, 200, 1, 1, 200, 1, 200, 1), 1'b1, "R6 mixed ties");
    drain();
  endtask

  task automatic testExtremes();
    step(pack8(0, 255, 0, 255, 0, 255, 0, 255), 1'b1, "R8 min max alternating");
    step(pack8(255, 255, 255, 255, 255, 255, 255, 0), 1'b1, "R8 single zero");
    step(pack8(0, 0, 0, 0, 0, 0, 0, 255), 1'b1, "R8 single max");
    drain();
  endtask

  task automatic testGaps();
    for (int i = 0; i < 40; i++) begin
      logic [L*W-1:0] v;
      for (int k = 0; k < L; k++) v[k*W +: W] = W'($urandom);
      step(v, (i % 3) != 1, (i % 3) != 1 ? "R9 valid between gaps" : "R9 gap");
    end
    drain();
  endtask

  task automatic testStream();
    for (int i = 0; i < 300; i++) begin
      logic [L*W-1:0] v;
      for (int k = 0; k < L; k++) v[k*W +: W] = (i % 2 == 0) ? W'($urandom) : W'($urandom % 4);
      step(v, 1'b1, "R5 back-to-back");
    end
    drain();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testSingle();
    testSkew();
    testTies();
    testExtremes();
    testGaps();
    testStream();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule